// File: doc/BRIEF.md
# Depth Block Constant Value Reconstructor

This block recovers the two constant values of a depth block that is split into two regions by a binary pattern. The caller presents three corner bits of the pattern (top-left, top-right, bottom-left), one signed delta per region, and eight already-reconstructed neighbour samples: four from the row above (top-left, top-middle, top-right, beyond-top-right) and four from the column on the left (left-top, left-middle, left-bottom, below-left-bottom). Missing neighbours are replaced by the caller before they reach the block.

Comparing the corner bits selects one of four prediction cases. Each case picks neighbour samples, rounded averages, or the sample with the larger gradient as the predicted value of each region. The matching delta is then added to each prediction and the result is clipped to the sample range. A one-cycle start strobe latches the result, and a valid pulse appears on the following cycle.

Top module: `depth_cpv_recon`

## Requirements
- R1: While rst_ni is low, and after it is released until the first strobe, valid_o is 0 and cpv0_o and cpv1_o are 0.
- R2: valid_o is 1 in the cycle after a cycle with start_i high, and 0 in the cycle after a cycle with start_i low.
- R3: When start_i is low, cpv0_o and cpv1_o keep their values at the next edge, whatever the other inputs do.
- R4: Let top_flag = p_tl_i XOR p_tr_i and left_flag = p_tl_i XOR p_bl_i. When both are 0, prediction 0 is avg(s_tl_i, s_lt_i). Prediction 1 is s_trr_i if |s_trr_i - s_tl_i| > |s_lbb_i - s_lb_i|. Otherwise, including when the two are equal, prediction 1 is s_lbb_i.
- R5: When both flags are 1, prediction 0 is avg(s_lb_i, s_tr_i) and prediction 1 is avg(s_tl_i, s_lt_i).
- R6: When top_flag is 1 and left_flag is 0, prediction 0 is s_lm_i and prediction 1 is s_tr_i.
- R7: When top_flag is 0 and left_flag is 1, prediction 0 is s_lb_i and prediction 1 is s_tm_i.
- R8: avg(a,b) is (a+b+1)>>1 on 8-bit unsigned samples, computed without overflow, so avg(255,255)=255 and avg(1,2)=2.
- R9: cpv0_o = clip(prediction 0 + delta0_i) and cpv1_o = clip(prediction 1 + delta1_i). Each delta is 9-bit two's complement, and clip limits the result to 0..255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Strobe: latch the result of the present inputs |
| p_tl_i | input | 1 | Pattern bit, top-left corner |
| p_tr_i | input | 1 | Pattern bit, top-right corner |
| p_bl_i | input | 1 | Pattern bit, bottom-left corner |
| delta0_i | input | 9 | Signed delta, region 0 |
| delta1_i | input | 9 | Signed delta, region 1 |
| s_tl_i | input | 8 | Row above, top-left sample |
| s_tm_i | input | 8 | Row above, middle sample |
| s_tr_i | input | 8 | Row above, top-right sample |
| s_trr_i | input | 8 | Row above, sample beyond top-right |
| s_lt_i | input | 8 | Left column, top sample |
| s_lm_i | input | 8 | Left column, middle sample |
| s_lb_i | input | 8 | Left column, bottom sample |
| s_lbb_i | input | 8 | Left column, sample below bottom |
| valid_o | output | 1 | Result valid pulse |
| cpv0_o | output | 8 | Reconstructed constant, region 0 |
| cpv1_o | output | 8 | Reconstructed constant, region 1 |

## Verification
The assertions check on every cycle how the valid pulse follows the strobe and that the outputs stay unchanged between strobes. With zero deltas, they also check the sample routing in the two edge cases where the flags differ, and that a most-negative delta forces the result to zero. The averaging and rounding, the gradient comparison and its tie rule, and saturation at the top of the range depend on sample values. Only the bench scenarios show these, using directed corner values and seeded random vectors that it compares with its own model.

// File: rtl/depth_cpv_pkg.sv
package depth_cpv_pkg;
  typedef enum logic [1:0] {
    CASE_FLAT  = 2'd0, // both flags clear
    CASE_DIAG  = 2'd1, // both flags set
    CASE_TOPE  = 2'd2, // top flag only
    CASE_LEFTE = 2'd3  // left flag only
  } cpv_case_e;
endpackage

// File: rtl/depth_cpv_avg.sv
module depth_cpv_avg #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] avg_o
);
  logic [W:0] sum;
  assign sum   = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(1);
  assign avg_o = sum[W:1];
endmodule

// File: rtl/depth_cpv_pred.sv
module depth_cpv_pred
  import depth_cpv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         p_tl_i,
  input  logic         p_tr_i,
  input  logic         p_bl_i,
  input  logic [W-1:0] s_tl_i,
  input  logic [W-1:0] s_tm_i,
  input  logic [W-1:0] s_tr_i,
  input  logic [W-1:0] s_trr_i,
  input  logic [W-1:0] s_lt_i,
  input  logic [W-1:0] s_lm_i,
  input  logic [W-1:0] s_lb_i,
  input  logic [W-1:0] s_lbb_i,
  output logic [W-1:0] pred0_o,
  output logic [W-1:0] pred1_o
);
  logic      top_flag, left_flag;
  cpv_case_e sel;
  logic [W-1:0] avg_corner, avg_far;
  logic [W:0]   d_top, d_left, m_top, m_left;
  logic [W-1:0] grad_pick;

  assign top_flag  = p_tl_i ^ p_tr_i;
  assign left_flag = p_tl_i ^ p_bl_i;

  always_comb begin
    unique case ({top_flag, left_flag})
      2'b00:   sel = CASE_FLAT;
      2'b11:   sel = CASE_DIAG;
      2'b10:   sel = CASE_TOPE;
      default: sel = CASE_LEFTE;
    endcase
  end

  depth_cpv_avg #(.W(W)) u_avg_corner (.a_i(s_tl_i), .b_i(s_lt_i), .avg_o(avg_corner));
  depth_cpv_avg #(.W(W)) u_avg_far    (.a_i(s_lb_i), .b_i(s_tr_i), .avg_o(avg_far));

  // gradient magnitudes along each outer edge
  assign d_top  = {1'b0, s_trr_i} - {1'b0, s_tl_i};
  assign d_left = {1'b0, s_lbb_i} - {1'b0, s_lb_i};
  assign m_top  = d_top[W]  ? (~d_top + 1'b1)  : d_top;
  assign m_left = d_left[W] ? (~d_left + 1'b1) : d_left;
  assign grad_pick = (m_top > m_left) ? s_trr_i : s_lbb_i;

  always_comb begin
    unique case (sel)
      CASE_FLAT:  begin pred0_o = avg_corner; pred1_o = grad_pick;  end
      CASE_DIAG:  begin pred0_o = avg_far;    pred1_o = avg_corner; end
      CASE_TOPE:  begin pred0_o = s_lm_i;     pred1_o = s_tr_i;     end
      default:    begin pred0_o = s_lb_i;     pred1_o = s_tm_i;     end
    endcase
  end
endmodule

// File: rtl/depth_cpv_add_clip.sv
module depth_cpv_add_clip #(
  parameter int SW = 8,
  parameter int DW = 9
) (
  input  logic [SW-1:0] pred_i,
  input  logic [DW-1:0] delta_i,
  output logic [SW-1:0] val_o
);
  localparam int SUM_W = ((SW > DW) ? SW : DW) + 2;
  logic signed [SUM_W-1:0] sum;

  assign sum = $signed({{(SUM_W-SW){1'b0}}, pred_i})
             + $signed({{(SUM_W-DW){delta_i[DW-1]}}, delta_i});

  always_comb begin
    if (sum[SUM_W-1])                val_o = '0;
    else if (|sum[SUM_W-2:SW])       val_o = '1;
    else                             val_o = sum[SW-1:0];
  end
endmodule

// File: rtl/depth_cpv_recon.sv
module depth_cpv_recon #(
  parameter int SAMPLE_W = 8,
  parameter int DELTA_W  = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                p_tl_i,
  input  logic                p_tr_i,
  input  logic                p_bl_i,
  input  logic [DELTA_W-1:0]  delta0_i,
  input  logic [DELTA_W-1:0]  delta1_i,
  input  logic [SAMPLE_W-1:0] s_tl_i,
  input  logic [SAMPLE_W-1:0] s_tm_i,
  input  logic [SAMPLE_W-1:0] s_tr_i,
  input  logic [SAMPLE_W-1:0] s_trr_i,
  input  logic [SAMPLE_W-1:0] s_lt_i,
  input  logic [SAMPLE_W-1:0] s_lm_i,
  input  logic [SAMPLE_W-1:0] s_lb_i,
  input  logic [SAMPLE_W-1:0] s_lbb_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] cpv0_o,
  output logic [SAMPLE_W-1:0] cpv1_o
);
  localparam int NREG = 2;

  logic [NREG-1:0][SAMPLE_W-1:0] pred, recon, cpv_q;
  logic [NREG-1:0][DELTA_W-1:0]  delta;
  logic                          valid_q;

  assign delta[0] = delta0_i;
  assign delta[1] = delta1_i;

  depth_cpv_pred #(.W(SAMPLE_W)) u_pred (
    .p_tl_i (p_tl_i),  .p_tr_i (p_tr_i),  .p_bl_i (p_bl_i),
    .s_tl_i (s_tl_i),  .s_tm_i (s_tm_i),  .s_tr_i (s_tr_i),  .s_trr_i(s_trr_i),
    .s_lt_i (s_lt_i),  .s_lm_i (s_lm_i),  .s_lb_i (s_lb_i),  .s_lbb_i(s_lbb_i),
    .pred0_o(pred[0]), .pred1_o(pred[1])
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    depth_cpv_add_clip #(.SW(SAMPLE_W), .DW(DELTA_W)) u_add (
      .pred_i (pred[g]),
      .delta_i(delta[g]),
      .val_o  (recon[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cpv_q   <= '0;
    end else begin
      valid_q <= start_i;
      if (start_i) cpv_q <= recon;
    end
  end

  assign valid_o = valid_q;
  assign cpv0_o  = cpv_q[0];
  assign cpv1_o  = cpv_q[1];
endmodule

// File: rtl/depth_cpv_chk.sv
module depth_cpv_chk #(
  parameter int SAMPLE_W = 8,
  parameter int DELTA_W  = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                p_tl_i,
  input logic                p_tr_i,
  input logic                p_bl_i,
  input logic [DELTA_W-1:0]  delta0_i,
  input logic [DELTA_W-1:0]  delta1_i,
  input logic [SAMPLE_W-1:0] s_tm_i,
  input logic [SAMPLE_W-1:0] s_tr_i,
  input logic [SAMPLE_W-1:0] s_lm_i,
  input logic [SAMPLE_W-1:0] s_lb_i,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] cpv0_o,
  input logic [SAMPLE_W-1:0] cpv1_o
);
  localparam logic [DELTA_W-1:0] DMIN = {1'b1, {(DELTA_W-1){1'b0}}};

  a_r2_valid_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  a_r2_valid_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);
  a_r3_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(cpv0_o) && $stable(cpv1_o)));
  a_r6_top_edge_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (p_tl_i != p_tr_i) && (p_tl_i == p_bl_i) && delta0_i == '0 && delta1_i == '0)
    |=> (cpv0_o == $past(s_lm_i) && cpv1_o == $past(s_tr_i)));
  a_r7_left_edge_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (p_tl_i == p_tr_i) && (p_tl_i != p_bl_i) && delta0_i == '0 && delta1_i == '0)
    |=> (cpv0_o == $past(s_lb_i) && cpv1_o == $past(s_tm_i)));
  a_r9_clip_low0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && delta0_i == DMIN) |=> cpv0_o == '0);
  a_r9_clip_low1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && delta1_i == DMIN) |=> cpv1_o == '0);
endmodule

bind depth_cpv_recon depth_cpv_chk #(.SAMPLE_W(SAMPLE_W), .DELTA_W(DELTA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .p_tl_i(p_tl_i), .p_tr_i(p_tr_i), .p_bl_i(p_bl_i),
  .delta0_i(delta0_i), .delta1_i(delta1_i),
  .s_tm_i(s_tm_i), .s_tr_i(s_tr_i), .s_lm_i(s_lm_i), .s_lb_i(s_lb_i),
  .valid_o(valid_o), .cpv0_o(cpv0_o), .cpv1_o(cpv1_o)
);

// File: tb/depth_cpv_recon_tb.sv
`timescale 1ns/1ps
module depth_cpv_recon_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ptl = 1'b0, ptr = 1'b0, pbl = 1'b0;
  logic [8:0] d0 = '0, d1 = '0;
  logic [7:0] tl = '0, tm = '0, tr = '0, trr = '0, lt = '0, lm = '0, lb = '0, lbb = '0;
  logic valid;
  logic [7:0] c0, c1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  depth_cpv_recon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .p_tl_i(ptl), .p_tr_i(ptr), .p_bl_i(pbl),
    .delta0_i(d0), .delta1_i(d1),
    .s_tl_i(tl), .s_tm_i(tm), .s_tr_i(tr), .s_trr_i(trr),
    .s_lt_i(lt), .s_lm_i(lm), .s_lb_i(lb), .s_lbb_i(lbb),
    .valid_o(valid), .cpv0_o(c0), .cpv1_o(c1)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int avg2(input int a, input int b);
    return (a + b + 1) / 2;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // expected prediction for region r (R4..R8)
  function automatic int model_pred(input int r);
    bit ft, fl;
    int p0, p1;
    ft = ptl ^ ptr;
    fl = ptl ^ pbl;
    if (!ft && !fl) begin
      p0 = avg2(tl, lt);
      p1 = (absd(trr, tl) > absd(lbb, lb)) ? int'(trr) : int'(lbb);
    end else if (ft && fl) begin
      p0 = avg2(lb, tr);
      p1 = avg2(tl, lt);
    end else if (ft) begin
      p0 = lm; p1 = tr;
    end else begin
      p0 = lb; p1 = tm;
    end
    return (r == 0) ? p0 : p1;
  endfunction

  function automatic int model_cpv(input int r);
    int v;
    v = model_pred(r) + ((r == 0) ? int'($signed(d0)) : int'($signed(d1)));
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  // drive at negedge, strobe one cycle, check at following negedges
  task automatic run_vec(input string req);
    int e0, e1;
    e0 = model_cpv(0);
    e1 = model_cpv(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R2 valid"}, int'(valid), 1);
    check({req, " cpv0"}, int'(c0), e0);
    check({req, " cpv1"}, int'(c1), e1);
    // disturb inputs with strobe low: R3
    tl = ~tl; tr = ~tr; lb = ~lb; lm = ~lm; d0 = ~d0; ptl = ~ptl;
    @(negedge clk);
    check("R2 valid drops", int'(valid), 0);
    check("R3 hold cpv0", int'(c0), e0);
    check("R3 hold cpv1", int'(c1), e1);
  endtask

  task automatic set_samp(input int a, b, c, d, e, f, g, h);
    tl = 8'(a); tm = 8'(b); tr = 8'(c); trr = 8'(d);
    lt = 8'(e); lm = 8'(f); lb = 8'(g); lbb = 8'(h);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 reset valid", int'(valid), 0);
    check("R1 reset cpv0", int'(c0), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset valid", int'(valid), 0);
    check("R1 post-reset cpv1", int'(c1), 0);

    // R4 flat, gradient picks TRR
    {ptl, ptr, pbl} = 3'b000; d0 = 0; d1 = 0;
    set_samp(10, 0, 0, 200, 20, 0, 50, 60);
    run_vec("R4 trr");
    // R4 tie picks LBB
    {ptl, ptr, pbl} = 3'b111; d0 = 0; d1 = 0;
    set_samp(100, 0, 0, 130, 40, 0, 70, 100);
    run_vec("R4 tie");
    // R5 diagonal with R8 rounding: avg(1,2)=2, avg(255,255)=255
    {ptl, ptr, pbl} = 3'b100; d0 = 0; d1 = 0;
    set_samp(1, 9, 255, 3, 2, 9, 255, 3);
    run_vec("R5 R8 diag");
    // R6 top edge
    {ptl, ptr, pbl} = 3'b010; d0 = 9'd5; d1 = 9'h1FD;
    set_samp(1, 2, 77, 4, 5, 88, 7, 8);
    run_vec("R6 top");
    // R7 left edge
    {ptl, ptr, pbl} = 3'b001; d0 = 9'd0; d1 = 9'd0;
    set_samp(1, 66, 3, 4, 5, 6, 99, 8);
    run_vec("R7 left");
    // R9 clip high and low
    {ptl, ptr, pbl} = 3'b010; d0 = 9'd255; d1 = 9'h100;
    set_samp(0, 0, 255, 0, 0, 250, 0, 0);
    run_vec("R9 clip");
    {ptl, ptr, pbl} = 3'b010; d0 = 9'h1FF; d1 = 9'd1;
    set_samp(0, 0, 254, 0, 0, 0, 0, 0);
    run_vec("R9 edge");

    for (int i = 0; i < 400; i++) begin
      {ptl, ptr, pbl} = 3'($urandom);
      d0 = 9'($urandom); d1 = 9'($urandom);
      set_samp($urandom, $urandom, $urandom, $urandom,
               $urandom, $urandom, $urandom, $urandom);
      run_vec("R4-9 random R9");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule